// File: doc/BRIEF.md
# Steerable Countdown Watchdog

This block is a watchdog whose timeout comes from one byte of configuration. A small multiplier field and a resolution field together set how many timing ticks may pass before the watchdog fires. A neighbouring time base supplies those ticks as a one-cycle enable at sixteen ticks per second. Software keeps the watchdog from firing in one of two ways: it rewrites the configuration byte, or it makes a restart access, which the surrounding register file turns into a one-cycle strobe. A multiplier of zero parks the watchdog so that it never fires.

When the countdown runs out, the block raises a sticky expiry flag. The top bit of the configuration byte then decides what happens next. If the bit is set, the block sends a one-cycle system reset request and, in the same cycle, clears its own configuration byte. It also tells the neighbouring control register to drop one of its bits through a one-cycle clear pulse. If the bit is clear, the block gives a one-cycle interrupt pulse instead. In both cases the countdown stops after it fires and waits for the next restart.

Top module: `wdt_steer`

## Requirements
- R1: After a restart, the watchdog fires on the T-th accepted tick, where T = M x 4^S. M is the value of configuration bits [6:2] and S is the value of bits [1:0]. Its outputs change in the cycle after that tick.
- R2: When bit 7 of the configuration is 1 at expiry, `rst_req_o` and `ctl_clr_o` are high for exactly one cycle, `irq_o` stays low, and `cfg_q_o` reads 0x00 from that cycle on.
- R3: When bit 7 is 0 at expiry, `irq_o` is high for exactly one cycle, `rst_req_o` and `ctl_clr_o` stay low, and the configuration value is kept.
- R4: A write stores the byte, which is seen on `cfg_q_o` in the next cycle, and restarts the countdown from the new timeout. A write wins over a restart strobe or a tick in the same cycle, so an expiry due in that cycle does not happen.
- R5: Expiry sets `flag_o`, and the flag stays set until the next restart.
- R6: A restart strobe reloads the countdown from the configuration byte already held and does not change it. Any restart, by write or by strobe, clears `flag_o` in the next cycle.
- R7: When M = 0, the watchdog never fires, whatever the value of S and however many ticks arrive.
- R8: After a reset-steered expiry, restart strobes alone do not rearm the watchdog. It fires again only after a new write.
- R9: After reset, `cfg_q_o` is 0x00, all outputs are low, and ticks cause no expiry.
- R10: After an interrupt-steered expiry, the countdown does not reload by itself, and further ticks give no further pulses until a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Configuration byte to write |
| kick_i | input | 1 | Restart strobe using the held configuration |
| tick_i | input | 1 | One-cycle timing tick (1/16 s) |
| cfg_q_o | output | 8 | Current configuration byte |
| flag_o | output | 1 | Sticky expiry flag |
| rst_req_o | output | 1 | One-cycle system reset request |
| ctl_clr_o | output | 1 | One-cycle clear for the neighbour control bit |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with its default field layout: a 5-bit multiplier, a 2-bit resolution field with a power-of-four step, and the steering bit at position 7. This gives an 11-bit counter and a longest timeout of 1984 ticks. Ticks arrive every cycle in the long cases, so the full 1984-tick timeout is run end to end within the cycle budget. The same-cycle collision of a write with the final tick can also be placed exactly.

// File: rtl/wdt_steer_pkg.sv
package wdt_steer_pkg;

   // Outcome of a countdown reaching zero
   typedef enum logic [1:0] {
      EXP_NONE = 2'd0,
      EXP_IRQ  = 2'd1,
      EXP_RST  = 2'd2
   } exp_kind_e;

   // Counter width needed for the largest multiplier times the largest scale
   function automatic int unsigned cnt_width(input int unsigned mult_w,
                                             input int unsigned res_w,
                                             input int unsigned res_step);
      return mult_w + res_step * ((1 << res_w) - 1);
   endfunction

endpackage

// File: rtl/wdt_tmo_decode.sv
module wdt_tmo_decode
   import wdt_steer_pkg::*;
#(
   parameter int unsigned CFG_W    = 8,
   parameter int unsigned MULT_W   = 5,
   parameter int unsigned MULT_LSB = 2,
   parameter int unsigned RES_W    = 2,
   parameter int unsigned RES_LSB  = 0,
   parameter int unsigned RES_STEP = 2,
   parameter int unsigned CNT_W    = cnt_width(MULT_W, RES_W, RES_STEP),
   parameter bit          USE_MULT = 1'b0
) (
   input  logic [CFG_W-1:0] cfg_i,
   output logic [CNT_W-1:0] ticks_o
);

   localparam int unsigned PAD_W = CNT_W - MULT_W;

   logic [MULT_W-1:0] mult;
   logic [RES_W-1:0]  res;
   logic [CNT_W-1:0]  mult_ext;

   assign mult     = cfg_i[MULT_LSB +: MULT_W];
   assign res      = cfg_i[RES_LSB +: RES_W];
   assign mult_ext = {{PAD_W{1'b0}}, mult};

   generate
      if (USE_MULT) begin : g_mult
         logic [CNT_W-1:0] scale;
         always_comb begin
            scale = '0;
            scale[RES_STEP * res] = 1'b1;
         end
         assign ticks_o = CNT_W'(mult_ext * scale);
      end else begin : g_shift
         assign ticks_o = mult_ext << (RES_STEP * res);
      end
   endgenerate

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
   parameter int unsigned CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             tick_i,
   output logic             expire_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   // A load in the same cycle takes priority over the final tick
   assign expire_o = tick_i && !load_i && (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (tick_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - ONE;
      end
   end

endmodule

// File: rtl/wdt_expiry_steer.sv
module wdt_expiry_steer
   import wdt_steer_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic expire_i,
   input  logic steer_rst_i,
   input  logic restart_i,
   output logic flag_o,
   output logic rst_req_o,
   output logic ctl_clr_o,
   output logic irq_o
);

   exp_kind_e kind;

   always_comb begin
      kind = EXP_NONE;
      if (expire_i) begin
         kind = steer_rst_i ? EXP_RST : EXP_IRQ;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o    <= 1'b0;
         rst_req_o <= 1'b0;
         ctl_clr_o <= 1'b0;
         irq_o     <= 1'b0;
      end else begin
         rst_req_o <= (kind == EXP_RST);
         ctl_clr_o <= (kind == EXP_RST);
         irq_o     <= (kind == EXP_IRQ);
         if (restart_i) begin
            flag_o <= 1'b0;
         end else if (kind != EXP_NONE) begin
            flag_o <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/wdt_steer.sv
module wdt_steer
   import wdt_steer_pkg::*;
#(
   parameter int unsigned CFG_W     = 8,
   parameter int unsigned MULT_W    = 5,
   parameter int unsigned MULT_LSB  = 2,
   parameter int unsigned RES_W     = 2,
   parameter int unsigned RES_LSB   = 0,
   parameter int unsigned RES_STEP  = 2,
   parameter int unsigned STEER_BIT = 7,
   parameter bit          USE_MULT  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             kick_i,
   input  logic             tick_i,
   output logic [CFG_W-1:0] cfg_q_o,
   output logic             flag_o,
   output logic             rst_req_o,
   output logic             ctl_clr_o,
   output logic             irq_o
);

   localparam int unsigned CNT_W = cnt_width(MULT_W, RES_W, RES_STEP);

   // Elaboration-time parameter checks
   generate
      if (RES_LSB + RES_W > MULT_LSB) begin : g_bad_res
         $error("resolution field overlaps multiplier field");
      end
      if (MULT_LSB + MULT_W > STEER_BIT) begin : g_bad_mult
         $error("multiplier field overlaps steering bit");
      end
      if (STEER_BIT >= CFG_W) begin : g_bad_steer
         $error("steering bit outside configuration byte");
      end
      if (CNT_W > 31) begin : g_bad_cnt
         $error("counter width too large");
      end
   endgenerate

   logic [CFG_W-1:0] cfg_q;
   logic [CFG_W-1:0] cfg_src;
   logic [CNT_W-1:0] load_val;
   logic             restart;
   logic             expire;

   assign restart = cfg_we || kick_i;
   assign cfg_src = cfg_we ? cfg_wdata : cfg_q;

   wdt_tmo_decode #(
      .CFG_W    (CFG_W),
      .MULT_W   (MULT_W),
      .MULT_LSB (MULT_LSB),
      .RES_W    (RES_W),
      .RES_LSB  (RES_LSB),
      .RES_STEP (RES_STEP),
      .CNT_W    (CNT_W),
      .USE_MULT (USE_MULT)
   ) u_decode (
      .cfg_i   (cfg_src),
      .ticks_o (load_val)
   );

   wdt_countdown #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (restart),
      .load_val_i (load_val),
      .tick_i     (tick_i),
      .expire_o   (expire)
   );

   wdt_expiry_steer u_steer (
      .clk         (clk),
      .rst_n       (rst_n),
      .expire_i    (expire),
      .steer_rst_i (cfg_q[STEER_BIT]),
      .restart_i   (restart),
      .flag_o      (flag_o),
      .rst_req_o   (rst_req_o),
      .ctl_clr_o   (ctl_clr_o),
      .irq_o       (irq_o)
   );

   // Configuration byte: written by software, wiped by a reset-steered expiry
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (cfg_we) begin
         cfg_q <= cfg_wdata;
      end else if (expire && cfg_q[STEER_BIT]) begin
         cfg_q <= '0;
      end
   end

   assign cfg_q_o = cfg_q;

endmodule

// File: rtl/wdt_steer_chk.sv
module wdt_steer_chk #(
   parameter int unsigned CFG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic             kick_i,
   input logic [CFG_W-1:0] cfg_q_o,
   input logic             flag_o,
   input logic             rst_req_o,
   input logic             ctl_clr_o,
   input logic             irq_o
);

   // R2
   rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |=> !rst_req_o);

   // R2
   rst_wipes_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> (cfg_q_o == '0) && ctl_clr_o);

   // R3
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   // R3
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_o, rst_req_o}));

   // R5
   flag_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o || rst_req_o) |-> flag_o);

   // R6
   restart_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we || kick_i) |=> !flag_o);

   // R6
   kick_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kick_i && !cfg_we) |=> $stable(cfg_q_o));

endmodule

bind wdt_steer wdt_steer_chk #(.CFG_W(CFG_W)) u_chk (.*);

// File: tb/wdt_steer_tb_top.sv
module wdt_steer_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic       kick_i = 1'b0;
   logic       tick_i = 1'b0;
   logic [7:0] cfg_q_o;
   logic       flag_o, rst_req_o, ctl_clr_o, irq_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   wdt_steer dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .kick_i(kick_i), .tick_i(tick_i), .cfg_q_o(cfg_q_o), .flag_o(flag_o),
      .rst_req_o(rst_req_o), .ctl_clr_o(ctl_clr_o), .irq_o(irq_o)
   );

   // Behavioural reference model
   int  m_cfg = 0;
   int  m_left = 0;
   bit  m_flag = 0, m_irq = 0, m_rst = 0, m_clr = 0;

   function automatic int tmo(input int c);
      return ((c >> 2) & 31) * (4 ** (c & 3));
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cfg = 0; m_left = 0; m_flag = 0; m_irq = 0; m_rst = 0; m_clr = 0;
      end else begin
         m_irq = 0; m_rst = 0; m_clr = 0;
         if (cfg_we) begin
            m_cfg = cfg_wdata; m_left = tmo(cfg_wdata); m_flag = 0;
         end else if (kick_i) begin
            m_left = tmo(m_cfg); m_flag = 0;
         end else if (tick_i && m_left > 0) begin
            m_left = m_left - 1;
            if (m_left == 0) begin
               m_flag = 1;
               if (m_cfg[7]) begin
                  m_rst = 1; m_clr = 1; m_cfg = 0;
               end else begin
                  m_irq = 1;
               end
            end
         end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Model comparison on every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R4", "cfg_q_o", cfg_q_o, m_cfg);
         chk("R5", "flag_o", flag_o, m_flag);
         chk("R2", "rst_req_o", rst_req_o, m_rst);
         chk("R2", "ctl_clr_o", ctl_clr_o, m_clr);
         chk("R3", "irq_o", irq_o, m_irq);
      end
   end

   task automatic drive(input bit we, input int d, input bit k, input bit t);
      @(negedge clk);
      cfg_we = we; cfg_wdata = 8'(d); kick_i = k; tick_i = t;
   endtask
   task automatic idle();           drive(0, 0, 0, 0);      endtask
   task automatic wr(input int d);  drive(1, d, 0, 0);      endtask
   task automatic kick();           drive(0, 0, 1, 0);      endtask
   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) drive(0, 0, 0, 1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();
      // R9: reset state and no expiry from ticks
      chk("R9", "cfg after reset", cfg_q_o, 0);
      chk("R9", "outputs after reset", {flag_o, rst_req_o, ctl_clr_o, irq_o}, 0);
      ticks(20); idle();
      chk("R9", "no fire when idle", {flag_o, irq_o, rst_req_o}, 0);

      // R1/R3: 0x05 -> 1 x 4 = 4 ticks, interrupt
      wr(8'h05); idle();
      chk("R4", "cfg stored", cfg_q_o, 8'h05);
      ticks(3); idle();
      chk("R1", "no irq before 4th tick", irq_o, 0);
      ticks(1); idle();
      chk("R1", "irq after 4th tick", irq_o, 1);
      chk("R5", "flag set", flag_o, 1);
      chk("R3", "cfg kept on irq", cfg_q_o, 8'h05);
      idle();
      chk("R3", "irq one cycle", irq_o, 0);
      // R10: no repeat without restart
      ticks(30); idle();
      chk("R10", "no second irq", irq_o, 0);
      chk("R5", "flag sticky", flag_o, 1);
      // R6: strobe restarts with held value
      kick(); idle();
      chk("R6", "kick clears flag", flag_o, 0);
      ticks(4); idle();
      chk("R6", "kick reloads held timeout", irq_o, 1);

      // R1 with res=2: 0x06 -> 16 ticks, gapped ticks
      wr(8'h06);
      for (int i = 0; i < 15; i++) begin ticks(1); idle(); idle(); end
      chk("R1", "no irq at 15 of 16", flag_o, 0);
      ticks(1); idle();
      chk("R1", "irq at 16 of 16", irq_o, 1);

      // R4: rewrite mid count restarts from new value
      wr(8'h09); ticks(6); wr(8'h05); ticks(3); idle();
      chk("R4", "rewrite restarts", irq_o | flag_o, 0);
      ticks(1); idle();
      chk("R4", "new timeout used", irq_o, 1);

      // R4: write beats final tick
      wr(8'h04); drive(1, 8'h04, 0, 1); idle();
      chk("R4", "write beats last tick", {irq_o, flag_o}, 0);
      ticks(1); idle();
      chk("R1", "single tick timeout", irq_o, 1);

      // R2: reset steering, 0x84 -> 1 tick
      wr(8'h84); ticks(1); idle();
      chk("R2", "rst_req", rst_req_o, 1);
      chk("R2", "ctl_clr", ctl_clr_o, 1);
      chk("R2", "cfg wiped", cfg_q_o, 0);
      chk("R2", "no irq on rst", irq_o, 0);
      idle();
      chk("R2", "rst one cycle", rst_req_o, 0);
      // R8: kicks alone do not rearm
      kick(); ticks(100); kick(); ticks(100); idle();
      chk("R8", "stays disabled", {flag_o, rst_req_o, irq_o}, 0);
      wr(8'h84); ticks(1); idle();
      chk("R8", "rearmed by write", rst_req_o, 1);

      // R7: zero multiplier never fires
      wr(8'h03); ticks(2500); idle();
      chk("R7", "mult zero never fires", {flag_o, irq_o, rst_req_o}, 0);
      wr(8'h83); ticks(300); idle();
      chk("R7", "mult zero with steer", {flag_o, rst_req_o}, 0);

      // R1: largest timeout 0x7F -> 31 x 64 = 1984
      wr(8'h7F); ticks(1983); idle();
      chk("R1", "no irq at 1983", flag_o, 0);
      ticks(1); idle();
      chk("R1", "irq at 1984", irq_o, 1);
      idle();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule